// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Buffer

This block gives a host register access to the five national spare bits of time slot 0 in an E1 line. The spare bits occupy bit slots 4 to 8 of time slot 0. They appear only in the odd frames, the ones that carry no frame alignment word. A CRC-4 multiframe has sixteen frames, so each spare-bit position delivers eight bits per multiframe, one per double frame. On the receive side the block gathers those bits into a working register per position. At each receive multiframe boundary it moves all five into visible registers and raises a sticky event flag. A host therefore always reads one complete multiframe and never a partly filled one.

On the transmit side the host writes five registers. At the transmit multiframe boundary they are copied into shadow registers and a second sticky flag is raised. The shadow bits are then inserted into the spare-bit slots of the time-slot-0 bit stream passing through. If the host writes nothing new, the same shadow contents go out again. A transparent control lets time slot 0 pass untouched. With the buffered mode switched off, the block falls back to a single five-bit word per direction, refreshed in every odd frame.

Both bit streams are valid-only. The line runs at a fixed rate, so the block has no ready signal and applies no back-pressure. It accepts every beat on which valid is high. The output stream repeats the input valid one cycle later, and its consumer must take every beat.

Top module: `e1_spare_buf`

## Requirements
- R1: After reset, every visible receive register, the receive simple word, both event flags, tx_out_vld and tx_out_bit are 0.
- R2: In buffered mode (buf_en=1), a receive beat in an odd frame 2k+1 at bit index 3+p (p=0..4, index 0 is bit slot 1) is stored as bit k of position p. One cycle after rx_mf_begin, the whole multiframe appears at rx_sa_word[8p+k].
- R3: rx_sa_word changes only in the cycle after a buffered-mode rx_mf_begin. It stays constant while a multiframe is being collected.
- R4: A buffered-mode boundary sets its flag (irq_rx_mf for receive, irq_tx_mf for transmit) in the next cycle. The flag then stays at 1 until its acknowledge pulse. When a boundary and an acknowledge arrive in the same cycle, the flag stays set.
- R5: In buffered mode, tx_mf_begin copies host registers 0..4 (written through host_addr 0..4) into the shadow registers. After that, on a beat at odd frame 2k+1 and index 3+p, tx_out_bit carries shadow bit k of position p. tx_out_vld and tx_out_bit follow the input beat by one cycle.
- R6: If the host writes nothing between two transmit boundaries, the next multiframe carries the same spare bits again.
- R7: Host writes made between transmit boundaries do not change the spare bits of the multiframe in progress.
- R8: While ts0_transp=1, tx_out_bit equals the input bit of the previous cycle for every beat, spare slots included.
- R9: Beats outside the spare slots (even frames, or indices 0..2) pass to tx_out_bit unchanged.
- R10: With buf_en=0, boundaries are ignored. No flag is set, rx_sa_word keeps its value, and the shadow registers are not loaded.
- R11: With buf_en=0, the word written at host_addr 5 (bits 4:0) is inserted in every odd frame, bit p at index 3+p. rx_sa_simple takes the five spare bits of each odd frame, bit p from index 3+p, one cycle after the index-7 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_en | input | 1 | Enables multiframe-buffered access |
| ts0_transp | input | 1 | Time-slot-0 transparent: no insertion |
| rx_vld | input | 1 | Receive time-slot-0 bit valid |
| rx_bit | input | 1 | Receive time-slot-0 bit |
| rx_frame | input | 4 | Receive frame number 0..15 |
| rx_idx | input | 3 | Receive bit index within time slot 0 |
| rx_mf_begin | input | 1 | Receive multiframe boundary pulse |
| tx_in_vld | input | 1 | Transmit input bit valid |
| tx_in_bit | input | 1 | Transmit input time-slot-0 bit |
| tx_frame | input | 4 | Transmit frame number 0..15 |
| tx_idx | input | 3 | Transmit bit index within time slot 0 |
| tx_mf_begin | input | 1 | Transmit multiframe boundary pulse |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | 0..4 position register, 5 simple word |
| host_wdata | input | 8 | Host write data |
| ack_rx_mf | input | 1 | Clears irq_rx_mf |
| ack_tx_mf | input | 1 | Clears irq_tx_mf |
| rx_sa_word | output | 40 | Visible receive registers, position p at [8p+7:8p] |
| rx_sa_simple | output | 5 | Simple-mode receive word |
| tx_out_vld | output | 1 | Transmit output valid |
| tx_out_bit | output | 1 | Transmit output bit |
| irq_rx_mf | output | 1 | Sticky receive boundary flag |
| irq_tx_mf | output | 1 | Sticky transmit boundary flag |

## Verification
The assertions assume that a boundary pulse never shares a cycle with a valid beat of the same direction. They also assume that frame numbers and indices run in line order, and that each ts0_transp or buf_en change falls between beats. The stimulus drives each beat in a cycle of its own, followed by an idle cycle, and pulses the boundaries only on idle cycles. Mode changes are made only between whole multiframes.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;
  parameter int NUM_SA    = 5;
  parameter int DF_PER_MF = 8;
  parameter int TS_BITS   = 8;
  parameter int SA_FIRST  = 3;
  parameter int FRAME_W   = 4;
  parameter int IDX_W     = $clog2(TS_BITS);
  parameter int POS_W     = $clog2(NUM_SA);
  parameter int DF_W      = $clog2(DF_PER_MF);
  parameter int ADDR_W    = 3;
  parameter int SIMPLE_ADDR = NUM_SA;
endpackage

// File: rtl/e1sa_slot_dec.sv
module e1sa_slot_dec
  import e1sa_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  input  logic [IDX_W-1:0]   idx,
  output logic               spare,
  output logic [POS_W-1:0]   pos,
  output logic [DF_W-1:0]    df
);
  always_comb begin
    spare = frame[0] && (int'(idx) >= SA_FIRST) && (int'(idx) < SA_FIRST + NUM_SA);
    pos   = POS_W'(idx - IDX_W'(SA_FIRST));
    df    = frame[FRAME_W-1:1];
  end
endmodule

// File: rtl/e1sa_flag.sv
module e1sa_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (ack) q <= 1'b0;
  end

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) set |=> q); // R4
  AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n) (ack && !set) |=> !q); // R4
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ack && !set) |=> $stable(q)); // R4
endmodule

// File: rtl/e1sa_rx_cap.sv
module e1sa_rx_cap
  import e1sa_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          buf_en,
  input  logic                          vld,
  input  logic                          bit_in,
  input  logic [FRAME_W-1:0]            frame,
  input  logic [IDX_W-1:0]              idx,
  input  logic                          mf_begin,
  output logic [NUM_SA*DF_PER_MF-1:0]   vis_flat,
  output logic [NUM_SA-1:0]             simple,
  output logic                          publish
);
  logic                 spare;
  logic [POS_W-1:0]     pos;
  logic [DF_W-1:0]      df;
  logic [DF_PER_MF-1:0] work [NUM_SA];
  logic [DF_PER_MF-1:0] vis  [NUM_SA];
  logic [NUM_SA-2:0]    sw_work;
  logic                 hit_last;

  e1sa_slot_dec u_dec (.frame(frame), .idx(idx), .spare(spare), .pos(pos), .df(df));

  assign publish  = mf_begin && buf_en;
  assign hit_last = vld && spare && (int'(pos) == NUM_SA - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_SA; p++) begin
        work[p] <= '0;
        vis[p]  <= '0;
      end
    end else if (publish) begin
      for (int p = 0; p < NUM_SA; p++) begin
        vis[p]  <= work[p];
        work[p] <= '0;
      end
    end else if (vld && spare) begin
      for (int p = 0; p < NUM_SA; p++)
        if (int'(pos) == p) work[p][df] <= bit_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_work <= '0;
      simple  <= '0;
    end else if (vld && spare) begin
      for (int p = 0; p < NUM_SA - 1; p++)
        if (int'(pos) == p) sw_work[p] <= bit_in;
      if (hit_last) simple <= {bit_in, sw_work};
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_SA; gp++) begin : g_flat
      assign vis_flat[gp*DF_PER_MF +: DF_PER_MF] = vis[gp];
    end
  endgenerate

  AST_RX_VIS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !publish |=> $stable(vis_flat)); // R3
  AST_RX_SIMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hit_last |=> $stable(simple)); // R11
endmodule

// File: rtl/e1sa_tx_ins.sv
module e1sa_tx_ins
  import e1sa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 buf_en,
  input  logic                 transp,
  input  logic                 host_wr,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [DF_PER_MF-1:0] host_wdata,
  input  logic                 mf_begin,
  input  logic                 in_vld,
  input  logic                 in_bit,
  input  logic [FRAME_W-1:0]   frame,
  input  logic [IDX_W-1:0]     idx,
  output logic                 out_vld,
  output logic                 out_bit,
  output logic                 load
);
  logic                           spare;
  logic [POS_W-1:0]               pos;
  logic [DF_W-1:0]                df;
  logic [DF_PER_MF-1:0]           hreg [NUM_SA];
  logic [DF_PER_MF-1:0]           shd  [NUM_SA];
  logic [NUM_SA-1:0]              simple_q;
  logic                           ins_val;
  logic [NUM_SA*DF_PER_MF-1:0]    shd_flat;

  e1sa_slot_dec u_dec (.frame(frame), .idx(idx), .spare(spare), .pos(pos), .df(df));

  assign load = mf_begin && buf_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_SA; p++) hreg[p] <= '0;
      simple_q <= '0;
    end else if (host_wr) begin
      for (int p = 0; p < NUM_SA; p++)
        if (host_addr == ADDR_W'(p)) hreg[p] <= host_wdata;
      if (host_addr == ADDR_W'(SIMPLE_ADDR)) simple_q <= host_wdata[NUM_SA-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_SA; p++) shd[p] <= '0;
    end else if (load) begin
      for (int p = 0; p < NUM_SA; p++) shd[p] <= hreg[p];
    end
  end

  always_comb begin
    ins_val = 1'b0;
    for (int p = 0; p < NUM_SA; p++)
      if (int'(pos) == p) ins_val = buf_en ? shd[p][df] : simple_q[p];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= in_vld;
      out_bit <= (in_vld && spare && !transp) ? ins_val : in_bit;
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < NUM_SA; gp++) begin : g_flat
      assign shd_flat[gp*DF_PER_MF +: DF_PER_MF] = shd[gp];
    end
  endgenerate

  AST_TX_SHD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(shd_flat)); // R7
  AST_TX_TRANSP: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && transp) |=> (out_bit == $past(in_bit))); // R8
  AST_TX_PASS: assert property (@(posedge clk) disable iff (!rst_n) (in_vld && !spare) |=> (out_bit == $past(in_bit))); // R9
  AST_TX_VLD: assert property (@(posedge clk) disable iff (!rst_n) in_vld |=> out_vld); // R5
endmodule

// File: rtl/e1_spare_buf.sv
module e1_spare_buf
  import e1sa_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        buf_en,
  input  logic                        ts0_transp,
  input  logic                        rx_vld,
  input  logic                        rx_bit,
  input  logic [FRAME_W-1:0]          rx_frame,
  input  logic [IDX_W-1:0]            rx_idx,
  input  logic                        rx_mf_begin,
  input  logic                        tx_in_vld,
  input  logic                        tx_in_bit,
  input  logic [FRAME_W-1:0]          tx_frame,
  input  logic [IDX_W-1:0]            tx_idx,
  input  logic                        tx_mf_begin,
  input  logic                        host_wr,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic [DF_PER_MF-1:0]        host_wdata,
  input  logic                        ack_rx_mf,
  input  logic                        ack_tx_mf,
  output logic [NUM_SA*DF_PER_MF-1:0] rx_sa_word,
  output logic [NUM_SA-1:0]           rx_sa_simple,
  output logic                        tx_out_vld,
  output logic                        tx_out_bit,
  output logic                        irq_rx_mf,
  output logic                        irq_tx_mf
);
  logic rx_pub;
  logic tx_load;

  e1sa_rx_cap u_rx (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .vld(rx_vld), .bit_in(rx_bit),
    .frame(rx_frame), .idx(rx_idx), .mf_begin(rx_mf_begin),
    .vis_flat(rx_sa_word), .simple(rx_sa_simple), .publish(rx_pub)
  );

  e1sa_tx_ins u_tx (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .transp(ts0_transp),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .mf_begin(tx_mf_begin), .in_vld(tx_in_vld), .in_bit(tx_in_bit),
    .frame(tx_frame), .idx(tx_idx), .out_vld(tx_out_vld), .out_bit(tx_out_bit),
    .load(tx_load)
  );

  e1sa_flag u_rx_flag (.clk(clk), .rst_n(rst_n), .set(rx_pub),  .ack(ack_rx_mf), .q(irq_rx_mf));
  e1sa_flag u_tx_flag (.clk(clk), .rst_n(rst_n), .set(tx_load), .ack(ack_tx_mf), .q(irq_tx_mf));

  AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !ack_rx_mf && !irq_rx_mf) |=> !irq_rx_mf); // R10
endmodule

// File: tb/test_e1_spare_buf.sv
module test_e1_spare_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_en = 1'b0, ts0_transp = 1'b0;
  logic rx_vld = 1'b0, rx_bit = 1'b0, rx_mf_begin = 1'b0;
  logic [3:0] rx_frame = '0, tx_frame = '0;
  logic [2:0] rx_idx = '0, tx_idx = '0, host_addr = '0;
  logic tx_in_vld = 1'b0, tx_in_bit = 1'b0, tx_mf_begin = 1'b0;
  logic host_wr = 1'b0, ack_rx_mf = 1'b0, ack_tx_mf = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [39:0] rx_sa_word;
  logic [4:0]  rx_sa_simple;
  logic tx_out_vld, tx_out_bit, irq_rx_mf, irq_tx_mf;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  e1_spare_buf i_e1_spare_buf (
    .clk(clk), .rst_n(rst_n), .buf_en(buf_en), .ts0_transp(ts0_transp),
    .rx_vld(rx_vld), .rx_bit(rx_bit), .rx_frame(rx_frame), .rx_idx(rx_idx),
    .rx_mf_begin(rx_mf_begin), .tx_in_vld(tx_in_vld), .tx_in_bit(tx_in_bit),
    .tx_frame(tx_frame), .tx_idx(tx_idx), .tx_mf_begin(tx_mf_begin),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .ack_rx_mf(ack_rx_mf), .ack_tx_mf(ack_tx_mf), .rx_sa_word(rx_sa_word),
    .rx_sa_simple(rx_sa_simple), .tx_out_vld(tx_out_vld), .tx_out_bit(tx_out_bit),
    .irq_rx_mf(irq_rx_mf), .irq_tx_mf(irq_tx_mf)
  );

  // {rx pattern, tx pattern}; position p at bits [8p+7:8p]
  localparam logic [79:0] VEC [0:3] = '{
    {40'h01_80_FF_00_A5, 40'h3C_C3_5A_A5_0F},
    {40'h12_34_56_78_9A, 40'hF0_0F_81_7E_55},
    {40'hFF_FF_00_00_FF, 40'h00_FF_00_FF_01},
    {40'hDE_AD_BE_EF_42, 40'h96_69_A5_5A_80}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic write_tx(input logic [39:0] t);
    for (int p = 0; p < 5; p++) host_write(3'(p), t[8*p +: 8]);
  endtask

  task automatic pulse(input logic rm, input logic tm, input logic ar, input logic ax);
    @(negedge clk);
    rx_mf_begin = rm; tx_mf_begin = tm; ack_rx_mf = ar; ack_tx_mf = ax;
    @(negedge clk);
    rx_mf_begin = 1'b0; tx_mf_begin = 1'b0; ack_rx_mf = 1'b0; ack_tx_mf = 1'b0;
  endtask

  task automatic play_mf(input logic [39:0] rxp, input logic [39:0] txp,
                         input logic use_simple, input logic [4:0] simp,
                         input logic transp_on, input logic mid_wr,
                         input logic chk_vis, input logic [39:0] vis_exp,
                         input string tag, input logic [7:0] seed);
    for (int f = 0; f < 16; f++) begin
      if (f == 8) begin
        if (chk_vis) chk("R3", 64'(rx_sa_word), 64'(vis_exp));
        if (mid_wr) host_write(3'd2, 8'hA5);
      end
      for (int b = 0; b < 8; b++) begin
        logic spare, tb, rb, exp;
        int k;
        k = f / 2;
        spare = (f % 2 == 1) && (b >= 3);
        tb = seed[(f + 3 * b) % 8] ^ b[0];
        rb = spare ? rxp[8 * (b - 3) + k] : seed[(f + b) % 8];
        @(negedge clk);
        rx_vld = 1'b1; rx_bit = rb; rx_frame = 4'(f); rx_idx = 3'(b);
        tx_in_vld = 1'b1; tx_in_bit = tb; tx_frame = 4'(f); tx_idx = 3'(b);
        @(negedge clk);
        rx_vld = 1'b0; tx_in_vld = 1'b0;
        if (!spare || transp_on) exp = tb;
        else if (use_simple) exp = simp[b - 3];
        else exp = txp[8 * (b - 3) + k];
        chk("R5", 64'(tx_out_vld), 64'd1);
        chk(!spare ? "R9" : (f >= 8 && mid_wr) ? "R7" : tag, 64'(tx_out_bit), 64'(exp));
        if (use_simple && spare && b == 7)
          chk("R11", 64'(rx_sa_simple),
              64'({rxp[32 + k], rxp[24 + k], rxp[16 + k], rxp[8 + k], rxp[k]}));
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [39:0] prev, snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(rx_sa_word), 64'd0);
    chk("R1", 64'(rx_sa_simple), 64'd0);
    chk("R1", 64'({irq_rx_mf, irq_tx_mf, tx_out_vld, tx_out_bit}), 64'd0);

    buf_en = 1'b1;
    prev = '0;
    for (int i = 0; i < 4; i++) begin
      write_tx(VEC[i][39:0]);
      pulse(1'b1, 1'b1, 1'b0, 1'b0);
      chk("R4", 64'(irq_rx_mf), 64'd1);
      chk("R5", 64'(irq_tx_mf), 64'd1);
      chk("R2", 64'(rx_sa_word), 64'(prev));
      pulse(1'b0, 1'b0, 1'b1, 1'b1);
      chk("R4", 64'({irq_rx_mf, irq_tx_mf}), 64'd0);
      play_mf(VEC[i][79:40], VEC[i][39:0], 1'b0, 5'd0, 1'b0, 1'b1, 1'b1, prev, "R5", 8'(8'h5B + i));
      prev = VEC[i][79:40];
    end

    // publish the last multiframe, then repeat without host writes
    write_tx(VEC[3][39:0]);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R2", 64'(rx_sa_word), 64'(prev));
    play_mf(40'h0, VEC[3][39:0], 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 40'h0, "R5", 8'h3D);
    pulse(1'b0, 1'b1, 1'b0, 1'b0);
    play_mf(40'h0, VEC[3][39:0], 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 40'h0, "R6", 8'hC7);

    // set wins over acknowledge
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    pulse(1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4", 64'(irq_rx_mf), 64'd1);
    pulse(1'b1, 1'b0, 1'b1, 1'b0);
    chk("R4", 64'(irq_rx_mf), 64'd1);
    pulse(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", 64'(irq_rx_mf), 64'd0);

    // transparent time slot 0
    ts0_transp = 1'b1;
    play_mf(40'h0, VEC[3][39:0], 1'b0, 5'd0, 1'b1, 1'b0, 1'b0, 40'h0, "R8", 8'hE1);
    ts0_transp = 1'b0;

    // buffered mode off
    pulse(1'b0, 1'b0, 1'b1, 1'b1);
    snap = rx_sa_word;
    buf_en = 1'b0;
    host_write(3'd5, 8'h16);
    write_tx({5{8'h3C}});
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10", 64'({irq_rx_mf, irq_tx_mf}), 64'd0);
    chk("R10", 64'(rx_sa_word), 64'(snap));
    play_mf(40'h5A_C3_0F_F0_99, 40'h0, 1'b1, 5'b10110, 1'b0, 1'b0, 1'b1, snap, "R11", 8'h94);
    pulse(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R10", 64'(rx_sa_word), 64'(snap));
    chk("R10", 64'({irq_rx_mf, irq_tx_mf}), 64'd0);
    buf_en = 1'b1;
    play_mf(40'h0, VEC[3][39:0], 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 40'h0, "R10", 8'h2A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule